// File: doc/BRIEF.md
# Camera Pixel Capture Downsampler

This block sits on the pixel-clock side of a parallel camera port. The camera sends RGB565 pixels one byte per clock while the line-valid strobe (`href`) is high. A frame strobe (`vsync`) marks frame boundaries. The block pairs each two bytes into a 16-bit pixel and reduces it to an 8-bit RGB332 value. It then presents that value to a frame buffer RAM, together with a column address, a row address and a write enable that lasts one clock.

Column and row counters follow the line and frame strobes. The column returns to zero whenever the line strobe is low. The row steps once on each falling edge of the line strobe. Both return to zero while the frame strobe is high. Writes beyond the configured picture size are dropped, so a camera that sends longer or more lines than the buffer holds cannot corrupt it.

Top module: `cam_pix_capture`

## Requirements
- R1: While `rst_n` is low and after it is released with `href` and `vsync` low, `we`, `wdata`, `x_addr` and `y_addr` are all zero.
- R2: While `href` is high, bytes alternate: the first byte sampled after `href` rises is the upper half [15:8] of a pixel and the next byte is the lower half [7:0]. The clock edge that samples the second byte raises `we` for exactly one cycle, and `we` is never high in two consecutive cycles.
- R3: `wdata` is RGB332 built from the pixel word p: `wdata[7:5]=p[15:13]`, `wdata[4:2]=p[10:8]`, `wdata[1:0]=p[4:3]`. Pixel 0xF81F gives 0xE3 and pixel 0x07E0 gives 0x1C. `wdata` holds its value while `we` is low.
- R4: During a write, `x_addr` is the column of that pixel. It starts at 0 on each line and rises by one on the clock edge after each write.
- R5: An edge that samples `href` low forces `x_addr` to 0 and suppresses writes. A byte pair cut short by `href` falling is discarded, and the next line again starts on an upper byte.
- R6: An edge that samples `href` low right after it was high increments `y_addr` by one.
- R7: An edge that samples `vsync` high clears `x_addr`, `y_addr` and the byte phase and suppresses writes, whatever `href` is doing.
- R8: Once `x_addr` reaches `LINE_W`, further pairs on that line raise no `we` and `x_addr` stays at `LINE_W`.
- R9: Once `y_addr` reaches `LINES`, it stays there until the frame strobe, and no writes occur.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Camera pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| href | input | 1 | Line-valid strobe; bytes are valid while high |
| vsync | input | 1 | Frame strobe; high clears the addresses |
| din | input | 8 | Camera data byte |
| x_addr | output | $clog2(LINE_W+1) | Column address of the pixel being written |
| y_addr | output | $clog2(LINES+1) | Row address of the pixel being written |
| wdata | output | 8 | RGB332 pixel for the frame buffer |
| we | output | 1 | One-cycle frame buffer write enable |

## Verification
The bound checker watches rules that hold on every clock:
- writes only follow a sampled-high `href`, never occur twice in a row, and never address outside the picture;
- `x_addr` is zero after `href` is low;
- both addresses are zero after `vsync`;
- addresses only step by one or return to zero.

The exact colour mapping, byte order and data values need the bench's reference model. So do the handling of odd byte counts, the saturation of both counters and recovery after a mid-line frame strobe.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;

    typedef logic [7:0]  byte_t;
    typedef logic [15:0] word565_t;

    // RGB565 -> RGB332: keep the top bits of each colour channel.
    function automatic byte_t to_rgb332(input word565_t p);
        return {p[15:13], p[10:8], p[4:3]};
    endfunction

endpackage

// File: rtl/cam_byte_pair.sv
module cam_byte_pair
    import cam_cap_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     href,
    input  logic     vsync,
    input  byte_t    din,
    output logic     pair_done,
    output word565_t pix_word
);

    typedef struct packed {
        logic  low_half;   // 1: next byte sampled is the lower half
        byte_t upper;      // stored upper byte of the pixel
    } pair_st_t;

    pair_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (vsync || !href) begin
            s_d.low_half = 1'b0;
        end else begin
            s_d.low_half = !s_q.low_half;
            if (!s_q.low_half) begin
                s_d.upper = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pair_done = href && !vsync && s_q.low_half;
    assign pix_word  = {s_q.upper, din};

endmodule

// File: rtl/cam_addr_gen.sv
module cam_addr_gen #(
    parameter int LINE_W = 176,
    parameter int LINES  = 144,
    localparam int X_W   = $clog2(LINE_W + 1),
    localparam int Y_W   = $clog2(LINES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           href,
    input  logic           vsync,
    input  logic           wr_done,
    output logic [X_W-1:0] x_addr,
    output logic [Y_W-1:0] y_addr,
    output logic           in_range
);

    localparam logic [X_W-1:0] X_LIM = X_W'(LINE_W);
    localparam logic [Y_W-1:0] Y_LIM = Y_W'(LINES);
    localparam logic [X_W-1:0] X_ONE = X_W'(1);
    localparam logic [Y_W-1:0] Y_ONE = Y_W'(1);

    typedef struct packed {
        logic           href_prev;
        logic [X_W-1:0] x;
        logic [Y_W-1:0] y;
    } addr_st_t;

    addr_st_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.href_prev = href;
        if (vsync) begin
            s_d.x = '0;
            s_d.y = '0;
        end else if (!href) begin
            s_d.x = '0;
            if (s_q.href_prev && (s_q.y < Y_LIM)) begin
                s_d.y = s_q.y + Y_ONE;
            end
        end else if (wr_done) begin
            s_d.x = s_q.x + X_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign x_addr   = s_q.x;
    assign y_addr   = s_q.y;
    assign in_range = (s_q.x < X_LIM) && (s_q.y < Y_LIM);

endmodule

// File: rtl/cam_pix_capture.sv
module cam_pix_capture
    import cam_cap_pkg::*;
#(
    parameter int LINE_W = 176,
    parameter int LINES  = 144,
    localparam int X_W   = $clog2(LINE_W + 1),
    localparam int Y_W   = $clog2(LINES + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           href,
    input  logic           vsync,
    input  logic [7:0]     din,
    output logic [X_W-1:0] x_addr,
    output logic [Y_W-1:0] y_addr,
    output logic [7:0]     wdata,
    output logic           we
);

    typedef struct packed {
        logic  we;
        byte_t wdata;
    } out_st_t;

    out_st_t  o_d, o_q;
    logic     pair_done;
    word565_t pix_word;
    logic     in_range;

    cam_byte_pair u_pair (
        .clk       (clk),
        .rst_n     (rst_n),
        .href      (href),
        .vsync     (vsync),
        .din       (din),
        .pair_done (pair_done),
        .pix_word  (pix_word)
    );

    cam_addr_gen #(
        .LINE_W (LINE_W),
        .LINES  (LINES)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .href     (href),
        .vsync    (vsync),
        .wr_done  (o_q.we),
        .x_addr   (x_addr),
        .y_addr   (y_addr),
        .in_range (in_range)
    );

    always_comb begin
        o_d    = o_q;
        o_d.we = pair_done && in_range;
        if (o_d.we) begin
            o_d.wdata = to_rgb332(pix_word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign we    = o_q.we;
    assign wdata = o_q.wdata;

endmodule

// File: rtl/cam_pix_capture_chk.sv
module cam_pix_capture_chk #(
    parameter int LINE_W = 176,
    parameter int LINES  = 144,
    localparam int X_W   = $clog2(LINE_W + 1),
    localparam int Y_W   = $clog2(LINES + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           href,
    input logic           vsync,
    input logic [X_W-1:0] x_addr,
    input logic [Y_W-1:0] y_addr,
    input logic           we
);

    localparam logic [X_W-1:0] X_LIM = X_W'(LINE_W);
    localparam logic [Y_W-1:0] Y_LIM = Y_W'(LINES);
    localparam logic [X_W-1:0] X_ONE = X_W'(1);
    localparam logic [Y_W-1:0] Y_ONE = Y_W'(1);

    // R2: a write only follows an edge that saw href high
    p_we_after_href_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $past(href));

    // R2: write pulses are isolated
    p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    // R4: column moves by one or returns to zero
    p_x_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (x_addr != $past(x_addr)) |-> (x_addr == '0 || x_addr == $past(x_addr) + X_ONE));

    // R5: href low zeroes the column and blocks writes
    p_x_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(href) |-> (x_addr == '0 && !we));

    // R6: row moves by one or returns to zero
    p_y_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (y_addr != $past(y_addr)) |-> (y_addr == '0 || y_addr == $past(y_addr) + Y_ONE));

    // R7: frame strobe clears both addresses
    p_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(vsync) |-> (x_addr == '0 && y_addr == '0 && !we));

    // R8, R9: addresses stay inside the picture on a write
    p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (x_addr < X_LIM && y_addr < Y_LIM));

    p_x_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        x_addr <= X_LIM);

    p_y_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        y_addr <= Y_LIM);

endmodule

bind cam_pix_capture cam_pix_capture_chk #(
    .LINE_W (LINE_W),
    .LINES  (LINES)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .href   (href),
    .vsync  (vsync),
    .x_addr (x_addr),
    .y_addr (y_addr),
    .we     (we)
);

// File: tb/cam_pix_capture_test.sv
module cam_pix_capture_test;

    localparam int LW = 8;
    localparam int NL = 4;
    localparam int XW = $clog2(LW + 1);
    localparam int YW = $clog2(NL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          href = 1'b0;
    logic          vsync = 1'b0;
    logic [7:0]    din = 8'h00;
    logic [XW-1:0] x_addr;
    logic [YW-1:0] y_addr;
    logic [7:0]    wdata;
    logic          we;

    int checks = 0;
    int bad = 0;
    string cur = "R1";

    // reference model state
    int m_ph = 0, m_hi = 0, m_x = 0, m_y = 0, m_we = 0, m_wd = 0, m_hp = 0;
    int lcg = 12345;

    always #10 clk = ~clk;

    cam_pix_capture #(.LINE_W(LW), .LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .href(href), .vsync(vsync), .din(din),
        .x_addr(x_addr), .y_addr(y_addr), .wdata(wdata), .we(we)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model(input int h, input int v, input int d);
        int nx = m_x, ny = m_y, nph = m_ph, nhi = m_hi, nwe = 0, nwd = m_wd;
        if (v != 0) begin
            nx = 0; ny = 0; nph = 0;
        end else if (h == 0) begin
            nx = 0; nph = 0;
            if (m_hp != 0 && m_y < NL) ny = m_y + 1;
        end else begin
            if (m_we != 0) nx = m_x + 1;
            if (m_ph == 0) begin
                nph = 1; nhi = d;
            end else begin
                nph = 0;
                if (m_x < LW && m_y < NL) begin
                    int p = m_hi * 256 + d;
                    nwe = 1;
                    nwd = (((p / 8192) % 8) * 32) + (((p / 256) % 8) * 4) + ((p / 8) % 4);
                end
            end
        end
        m_x = nx; m_y = ny; m_ph = nph; m_hi = nhi; m_we = nwe; m_wd = nwd; m_hp = h;
    endtask

    task automatic step(input logic h, input logic v, input logic [7:0] d);
        @(negedge clk);
        href = h; vsync = v; din = d;
        @(posedge clk);
        model(int'(h), int'(v), int'(d));
        #2;
        chk({cur, " we"}, int'(we), m_we);
        chk({cur, " wdata"}, int'(wdata), m_wd);
        chk({cur, " x_addr"}, int'(x_addr), m_x);
        chk({cur, " y_addr"}, int'(y_addr), m_y);
    endtask

    function automatic logic [7:0] next_byte();
        lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
        return 8'(lcg >>> 16);
    endfunction

    task automatic send_line(input int npix, input int gap);
        for (int i = 0; i < 2 * npix; i++) step(1'b1, 1'b0, next_byte());
        for (int i = 0; i < gap; i++) step(1'b0, 1'b0, 8'h00);
    endtask

    task automatic frame_strobe();
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b1, 8'h00);
        step(1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired in %s", cur);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1 we", int'(we), 0);
        chk("R1 x_addr", int'(x_addr), 0);
        chk("R1 y_addr", int'(y_addr), 0);
        chk("R1 wdata", int'(wdata), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 8'h00);
        step(1'b0, 1'b0, 8'h00);

        cur = "R7";
        frame_strobe();

        // R2/R4: explicit byte pairing and column timing
        cur = "R2";
        step(1'b1, 1'b0, 8'hA5);
        chk("R2 no write on first byte", int'(we), 0);
        step(1'b1, 1'b0, 8'h3C);
        chk("R2 write on second byte", int'(we), 1);
        chk("R4 first column", int'(x_addr), 0);
        step(1'b1, 1'b0, 8'h11);
        chk("R2 write lasts one cycle", int'(we), 0);
        chk("R4 column advanced", int'(x_addr), 1);
        step(1'b1, 1'b0, 8'h22);
        chk("R4 second column", int'(x_addr), 1);
        cur = "R4";
        send_line(3, 3);

        // R3: colour mapping with fixed pixels
        cur = "R3";
        step(1'b1, 1'b0, 8'hF8);
        step(1'b1, 1'b0, 8'h1F);
        chk("R3 pixel F81F", int'(wdata), 8'hE3);
        step(1'b1, 1'b0, 8'h07);
        chk("R3 wdata held", int'(wdata), 8'hE3);
        step(1'b1, 1'b0, 8'hE0);
        chk("R3 pixel 07E0", int'(wdata), 8'h1C);
        step(1'b0, 1'b0, 8'h00);
        chk("R6 row after line", int'(y_addr), 2);
        step(1'b0, 1'b0, 8'h00);

        // R5: odd byte count, next line starts on upper byte
        cur = "R5";
        frame_strobe();
        step(1'b1, 1'b0, 8'h55);
        step(1'b1, 1'b0, 8'h66);
        step(1'b1, 1'b0, 8'h77);
        step(1'b0, 1'b0, 8'h00);
        chk("R5 column cleared", int'(x_addr), 0);
        chk("R5 no write", int'(we), 0);
        step(1'b1, 1'b0, 8'h07);
        step(1'b1, 1'b0, 8'hE0);
        chk("R5 line restarts on upper byte", int'(wdata), 8'h1C);
        step(1'b0, 1'b0, 8'h00);

        // R8: line longer than the picture width
        cur = "R8";
        send_line(LW + 3, 0);
        chk("R8 column saturated", int'(x_addr), LW);
        step(1'b0, 1'b0, 8'h00);

        // R6/R9: run out of rows
        cur = "R9";
        send_line(2, 2);
        send_line(2, 2);
        chk("R9 row saturated", int'(y_addr), NL);
        step(1'b1, 1'b0, 8'h12);
        step(1'b1, 1'b0, 8'h34);
        chk("R9 no write past last row", int'(we), 0);
        step(1'b0, 1'b0, 8'h00);

        // R7: frame strobe in the middle of a line
        cur = "R7";
        frame_strobe();
        send_line(2, 2);
        step(1'b1, 1'b0, 8'h01);
        step(1'b1, 1'b0, 8'h02);
        step(1'b1, 1'b0, 8'h03);
        step(1'b1, 1'b1, 8'h04);
        chk("R7 x cleared", int'(x_addr), 0);
        chk("R7 y cleared", int'(y_addr), 0);
        step(1'b1, 1'b1, 8'h05);
        step(1'b1, 1'b0, 8'hF8);
        step(1'b1, 1'b0, 8'h1F);
        chk("R7 restart on upper byte", int'(wdata), 8'hE3);
        step(1'b0, 1'b0, 8'h00);

        // mixed frames with varying line lengths
        cur = "R6";
        for (int f = 0; f < 3; f++) begin
            frame_strobe();
            for (int l = 0; l < NL + 1; l++) send_line(3 + ((l + f) % 8), 1 + (l % 3));
        end

        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule